// File: doc/BRIEF.md
# Fractional Quarter-Step Baud Generator

This block derives the timing strobes of an asynchronous serial port from the peripheral clock. A programmable divider word selects the oversample period in quarter-clock steps. The block emits a one-cycle oversample strobe at sixteen times the bit rate, and a bit strobe on every sixteenth oversample strobe. The transmitter and receiver shift and sample on these strobes.

The divider field sits at bits 20..6 of the configuration word. Bits below bit 6 are ignored, and bit 6 is worth a quarter of a clock. The baud rate is 4·clk / (16·(4 + field)). Each oversample period is 1 + field/4 clocks, which is rarely a whole number. The whole part sets the base period length. The two fractional bits feed an accumulator, and each carry out of that accumulator stretches one period by a single clock. Over any four periods the average therefore matches the programmed value, and no single period is off by more than one clock.

A configuration write, or a low run enable, returns all counters and the accumulator to their starting point. After this the new rate starts from a clean phase.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, and until the first write, `cfg_rdata` reads zero. After a write it returns bits 20..6 of the written word in the same positions, with every other bit read as zero.
- R2: With a divider field of zero and `run_en` high, `os_tick` is high on every clock.
- R3: Let field F have whole part W = F>>2 and fraction Q = F[1:0]. The k-th oversample period after a restart lasts 1+W clocks, plus one clock exactly when floor(k·Q/4) exceeds floor((k−1)·Q/4). Over any four consecutive periods from a restart this totals 4+F clocks.
- R4: The first `os_tick` after a restart appears P1 clocks after the first clock edge that samples `run_en` high, or after the edge following the write edge. P1 is the first period given by R3.
- R5: `bit_tick` is a one-cycle pulse on every 16th `os_tick`, counted from a restart, and coincides with that `os_tick`.
- R6: While `run_en` is low, neither strobe is asserted, and the counters and accumulator are held at their start values.
- R7: A write to the divider restarts the period counter, the bit counter and the accumulator. No strobe is asserted in the cycle after the write edge.
- R8: Bits 5..0 of a written word have no effect on timing or on read-back.
- R9: The largest field, 32767, gives W = 8191 and Q = 3. Its first two periods are 8192 and 8193 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables the strobes; low holds everything at its start value |
| cfg_wr | input | 1 | Divider write strobe, one cycle |
| cfg_wdata | input | 32 | Divider word; field at bits 20..6 |
| cfg_rdata | output | 32 | Divider read-back |
| os_tick | output | 1 | Oversample strobe, 16 per bit |
| bit_tick | output | 1 | Bit-period strobe |

## Verification
The bench builds the block with its default parameters: a 15-bit field at bit 6, two fractional bits and 16x oversampling. This makes every fractional residue from zero to three reachable within a few periods. It also brings the largest field, with periods of about 8192 clocks, within the cycle budget, so both the whole-part range and the carry stretch can be seen at the top of the range. Field values one and zero show the carry feeding into the bit strobe position and the every-cycle strobe case.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Configuration word layout
  localparam int unsigned CFG_W     = 32;
  localparam int unsigned FIELD_LSB = 6;
  localparam int unsigned FIELD_W   = 15;
  // Fractional bits of the divider field (quarter-clock resolution)
  localparam int unsigned FRAC_W    = 2;
  // Oversample strobes per bit
  localparam int unsigned OVS       = 16;

  // Width of a period counter able to hold the longest period minus one
  function automatic int unsigned period_cnt_w(input int unsigned fw, input int unsigned frw);
    return fw - frw + 1;
  endfunction
endpackage

// File: rtl/baud_divreg.sv
module baud_divreg #(
  parameter int unsigned CFG_W     = baud_pkg::CFG_W,
  parameter int unsigned FIELD_LSB = baud_pkg::FIELD_LSB,
  parameter int unsigned FIELD_W   = baud_pkg::FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [CFG_W-1:0]   wdata_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [CFG_W-1:0]   rdata_o,
  output logic               restart_o
);
  localparam int unsigned FIELD_MSB = FIELD_LSB + FIELD_W - 1;

  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
    end else if (wr_i) begin
      field_q <= wdata_i[FIELD_MSB:FIELD_LSB];
    end
  end

  // Unused low and high bits read back as zero
  always_comb begin
    rdata_o = '0;
    rdata_o[FIELD_MSB:FIELD_LSB] = field_q;
  end

  assign field_o   = field_q;
  assign restart_o = wr_i;
endmodule

// File: rtl/baud_frac_stepper.sv
module baud_frac_stepper #(
  parameter int unsigned FIELD_W = baud_pkg::FIELD_W,
  parameter int unsigned FRAC_W  = baud_pkg::FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               restart_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               strobe_o,
  output logic               tick_o
);
  localparam int unsigned WHOLE_W = FIELD_W - FRAC_W;
  localparam int unsigned CNT_W   = baud_pkg::period_cnt_w(FIELD_W, FRAC_W);

  logic [WHOLE_W-1:0] whole;
  logic               carry;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   last_c;
  logic               active;
  logic               strobe;

  assign whole  = field_i[FIELD_W-1:FRAC_W];
  assign active = run_i && !restart_i;
  // Period length is whole+1 (+1 on carry), so the last count is whole+carry
  assign last_c = CNT_W'(whole) + CNT_W'(carry);
  assign strobe = active && (cnt_q == last_c);

  generate
    if (FRAC_W > 0) begin : g_dither
      logic [FRAC_W-1:0] acc_q;
      logic [FRAC_W:0]   sum;

      assign sum   = {1'b0, acc_q} + {1'b0, field_i[FRAC_W-1:0]};
      assign carry = sum[FRAC_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q <= '0;
        end else if (!active) begin
          acc_q <= '0;
        end else if (strobe) begin
          acc_q <= sum[FRAC_W-1:0];
        end
      end
    end else begin : g_integer
      assign carry = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= strobe;
      if (!active || strobe) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign strobe_o = strobe;
endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter #(
  parameter int unsigned OVS = baud_pkg::OVS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  input  logic strobe_i,
  output logic bit_tick_o
);
  localparam int unsigned BC_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [BC_W-1:0] LAST = BC_W'(OVS - 1);

  logic [BC_W-1:0] bcnt_q;
  logic            wrap;

  assign wrap = strobe_i && (bcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q     <= '0;
      bit_tick_o <= 1'b0;
    end else begin
      bit_tick_o <= wrap;
      if (!run_i || restart_i || wrap) begin
        bcnt_q <= '0;
      end else if (strobe_i) begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int unsigned CFG_W     = baud_pkg::CFG_W,
  parameter int unsigned FIELD_LSB = baud_pkg::FIELD_LSB,
  parameter int unsigned FIELD_W   = baud_pkg::FIELD_W,
  parameter int unsigned FRAC_W    = baud_pkg::FRAC_W,
  parameter int unsigned OVS       = baud_pkg::OVS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             os_tick,
  output logic             bit_tick
);
  logic [FIELD_W-1:0] field;
  logic               restart;
  logic               os_strobe;

  baud_divreg #(
    .CFG_W(CFG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W)
  ) u_divreg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata),
    .field_o(field), .rdata_o(cfg_rdata), .restart_o(restart)
  );

  baud_frac_stepper #(
    .FIELD_W(FIELD_W), .FRAC_W(FRAC_W)
  ) u_stepper (
    .clk(clk), .rst_n(rst_n), .run_i(run_en), .restart_i(restart),
    .field_i(field), .strobe_o(os_strobe), .tick_o(os_tick)
  );

  baud_bit_counter #(
    .OVS(OVS)
  ) u_bitcnt (
    .clk(clk), .rst_n(rst_n), .run_i(run_en), .restart_i(restart),
    .strobe_i(os_strobe), .bit_tick_o(bit_tick)
  );
endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
  parameter int unsigned CFG_W     = 32,
  parameter int unsigned FIELD_LSB = 6,
  parameter int unsigned FIELD_W   = 15,
  parameter int unsigned FRAC_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             os_tick,
  input logic             bit_tick
);
  localparam int unsigned MAXP = (1 << (FIELD_W - FRAC_W)) + 1;
  localparam logic [CFG_W-1:0] KEEP =
    CFG_W'(((64'd1 << FIELD_W) - 1) << FIELD_LSB);

  int unsigned gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 0;
    end else if (!run_en || cfg_wr || os_tick) begin
      gap_q <= 0;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !os_tick && !bit_tick);

  // R7
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !os_tick && !bit_tick);

  // R5
  bit_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  // R1
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == ($past(cfg_wdata) & KEEP));

  // R1
  readback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));

  // R3
  period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= MAXP);
endmodule

bind baud_frac_gen baud_frac_gen_chk #(
  .CFG_W(CFG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wr(cfg_wr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .os_tick(os_tick),
  .bit_tick(bit_tick)
);

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        os_tick;
  logic        bit_tick;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  baud_frac_gen dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .os_tick(os_tick),
    .bit_tick(bit_tick)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected length of the k-th period after a restart
  function automatic int exp_period(input int f, input int k);
    int w = f >> 2;
    int q = f & 3;
    return 1 + w + (((k * q) >> 2) - (((k - 1) * q) >> 2));
  endfunction

  // Returns at a falling edge; counts falling edges until os_tick is seen
  task automatic wait_tick(output int n);
    n = 0;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      n++;
      if (os_tick) return;
    end
    n = -1;
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic start_run();
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
  endtask

  task automatic t_reset();
    chk(os_tick == 1'b0, "R6", "os_tick after reset", os_tick, 0);
    chk(bit_tick == 1'b0, "R6", "bit_tick after reset", bit_tick, 0);
    chk(cfg_rdata == 32'h0, "R1", "rdata after reset", cfg_rdata, 0);
  endtask

  task automatic t_readback();
    write_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h001F_FFC0, "R1", "rdata all ones", cfg_rdata, 32'h001F_FFC0);
    write_cfg(32'h0000_003F);
    chk(cfg_rdata == 32'h0, "R8", "rdata low bits only", cfg_rdata, 0);
    write_cfg(32'hA5A5_5A5A);
    chk(cfg_rdata == (32'hA5A5_5A5A & 32'h001F_FFC0), "R1", "rdata pattern",
        cfg_rdata, 32'hA5A5_5A5A & 32'h001F_FFC0);
  endtask

  // Programs a word, restarts via run_en and checks nper periods (R3/R4)
  task automatic t_periods(input logic [31:0] w, input int nper, input string req);
    int f = int'(w[20:6]);
    int n;
    write_cfg(w);
    start_run();
    for (int k = 1; k <= nper; k++) begin
      wait_tick(n);
      chk(n == exp_period(f, k), req, $sformatf("field %0d period %0d", f, k),
          n, exp_period(f, k));
    end
    run_en = 1'b0;
  endtask

  task automatic t_zero_field();
    int ticks = 0;
    int bits = 0;
    int first_bit = -1;
    write_cfg(32'h0);
    start_run();
    for (int i = 1; i <= 48; i++) begin
      @(negedge clk);
      if (os_tick) ticks++;
      if (bit_tick) begin
        bits++;
        if (first_bit < 0) first_bit = i;
      end
    end
    chk(ticks == 48, "R2", "os ticks in 48 cycles", ticks, 48);
    chk(bits == 3, "R5", "bit ticks in 48 cycles", bits, 3);
    chk(first_bit == 16, "R5", "first bit tick cycle", first_bit, 16);
    run_en = 1'b0;
  endtask

  task automatic t_bit_with_carry();
    // field 1: periods 1,1,1,2 -> 16 strobes take 20 clocks
    int first_bit = -1;
    int os_at_bit = 0;
    write_cfg(32'h0000_0040);
    start_run();
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk);
      if (bit_tick && first_bit < 0) begin
        first_bit = i;
        os_at_bit = os_tick;
      end
    end
    chk(first_bit == 20, "R5", "bit tick with dither", first_bit, 20);
    chk(os_at_bit == 1, "R5", "os_tick with bit tick", os_at_bit, 1);
    run_en = 1'b0;
  endtask

  task automatic t_run_gate();
    int seen = 0;
    int n;
    write_cfg(32'd9 << 6); // W=2, Q=1
    start_run();
    repeat (7) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) seen++;
    end
    chk(seen == 0, "R6", "strobes while idle", seen, 0);
    run_en = 1'b1;
    wait_tick(n);
    chk(n == 3, "R6", "first period after re-enable", n, 3);
    wait_tick(n);
    chk(n == 3, "R6", "second period after re-enable", n, 3);
    run_en = 1'b0;
  endtask

  task automatic t_write_restart();
    int n;
    int early = 0;
    write_cfg(32'd40 << 6); // P=11
    start_run();
    repeat (5) @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = 32'd8 << 6; // P=3
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = '0;
    early = os_tick;
    chk(early == 0, "R7", "strobe after write edge", early, 0);
    wait_tick(n);
    chk(n == 3, "R7", "first period after write", n, 3);
    run_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_zero_field();
    t_periods(32'd4 << 6, 4, "R3");
    t_periods(32'd5 << 6, 8, "R3");
    t_periods(32'd6 << 6, 8, "R3");
    t_periods(32'd7 << 6, 8, "R3");
    t_periods(32'd2 << 6, 4, "R4");
    t_periods((32'd7 << 6) | 32'h3F, 8, "R8");
    t_bit_with_carry();
    t_run_gate();
    t_write_restart();
    t_periods(32'd32767 << 6, 2, "R9");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule